// File: doc/BRIEF.md
# Table-Driven Four-Switch PWM Sequencer

This block drives the four gate signals of a bidirectional buck-boost power stage. The four switches form two half-bridges. Half-bridge A holds VT1 and VT2, and half-bridge B holds VT3 and VT4. A conversion period starts on each period tick. On that tick the block picks one entry from a preloaded timing table and uses it for the whole period, so no arithmetic on voltages or currents is done at run time. The table is addressed by a stepped power command and a quantized battery-voltage code. Each entry gives three edge times, t1 < t2 < t3, counted in clock cycles from the tick. It also gives one turn-on delay per switching event, which produces the dead time needed for soft switching.

Within a period the gates pass through four states: VT1+VT4, then VT1+VT3, then VT2+VT3, then VT2+VT4. A per-entry mode bit selects low-power or high-power operation. In low-power mode, an inductor-current comparator pulse that arrives after t2 ends the third interval early. The entry's t3 acts as a cap, and t3 may not exceed 90% of the period. In high-power mode, t3 always comes from the table and the comparator has no effect.

An entry that breaks the ordering rule is never applied. The block flags it and reuses the last good entry. Software or a loader fills the table through a simple write port.

Top module: `pwm4_table_seq`

## Requirements
- R1: After reset, `gate` is 4'b0000 and `entry_err` is 0. All gates stay off until a tick latches a valid entry.
- R2: Table address and entry format:
  - The table address is {vbat_code, pwr_cmd}, with vbat_code in the upper bits.
  - An entry is packed, from the MSB down, as {hp, d3, d2, d1, d0, t3, t2, t1}.
  - The entry is read and latched only in the cycle where per_tick is high. Later changes to pwr_cmd, vbat_code or the table do not affect the period already running.
- R3: Gate bits are gate[0]=VT1, gate[1]=VT2, gate[2]=VT3, gate[3]=VT4. Outside dead times the pattern is:
  - 4'b1001 before edge 1;
  - 4'b0101 between edges 1 and 2;
  - 4'b0110 between edges 2 and 3;
  - 4'b1010 after edge 3.
- R4: Let m count clock edges after the edge that samples per_tick (m=0 at that edge). For an edge at count value t, the outgoing switch turns off at m=t+2. Edge 1 turns off VT4, edge 2 turns off VT1 and edge 3 turns off VT3.
- R5: Each incoming switch turns on at m=t+3+d, using its own delay from the entry. The pairings are:
  - edge 1: VT3 with d1;
  - edge 2: VT2 with d2;
  - edge 3: VT4 with d3;
  - period start, from the second period on: VT2 turns off at m=1 and VT1 turns on at m=2+d0.
- R6: In low-power mode (hp=0), a cur_trip pulse sampled while the count equals c moves edge 3 to c when t2 < c < t3. A pulse with c ≤ t2 is ignored.
- R7: If no accepted comparator pulse arrives, edge 3 occurs at the entry's t3. A valid t3 never exceeds T3MAX = 9·PERIOD/10 cycles.
- R8: In high-power mode (hp=1), cur_trip has no effect and edge 3 occurs at t3.
- R9: An entry is valid only if t1 < t2 < t3 ≤ T3MAX.
  - On a tick with an invalid entry, entry_err is 1 for that period and the last valid entry is used again.
  - If no valid entry has been latched since reset, the block stays idle with all gates off.
- R10: VT1 and VT2 are never on together, and VT3 and VT4 are never on together.
- R11: When a table write hits the address being latched in the same cycle as the tick, the old contents are used for this period and the new contents for the next one.
- R12: In the first period after idle, VT1 and VT4 turn on together at m=1, with no dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all times are counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| per_tick | input | 1 | One-cycle pulse that starts a conversion period |
| pwr_cmd | input | PW_W | Stepped power command (low table address bits) |
| vbat_code | input | VB_W | Quantized battery-voltage code (high table address bits) |
| cur_trip | input | 1 | Inductor-current comparator flag |
| tab_we | input | 1 | Table write strobe |
| tab_addr | input | PW_W+VB_W | Table write address |
| tab_wdata | input | ENT_W | Packed table entry to write |
| gate | output | 4 | Gate drives for VT4..VT1 (bit 3..bit 0) |
| entry_err | output | 1 | The entry latched at the last tick was invalid |

## Verification
Two pairs of functions can fall in the same clock cycle, and both are provoked on purpose.

The first pair is a table write and the period tick, aimed at the same address. The bench issues the write on the tick cycle. It then judges that the first period follows the old edge times and that the next period follows the new ones.

The second pair is the comparator pulse and the t2 edge. The bench places the pulse exactly on the count of t2 and expects the table's t3 to stand. It also places pulses inside the t2..t3 window and expects edge 3 at the pulse.

Randomly chosen addresses, mid-period address changes and mid-period writes to other entries check that the latched entry alone sets every edge and delay.

// File: rtl/pwm4_seq_pkg.sv
// Shared types for the four-switch table-driven PWM sequencer.
package pwm4_seq_pkg;

    // Interval of a conversion period; advances A->B->C->D, back to A on a tick.
    typedef enum logic [1:0] {
        PH_A = 2'd0,   // VT1 + VT4
        PH_B = 2'd1,   // VT1 + VT3
        PH_C = 2'd2,   // VT2 + VT3
        PH_D = 2'd3    // VT2 + VT4
    } seq_phase_e;

endpackage

// File: rtl/pwm4_seq_table.sv
// Timing table: flop-based storage, one write port, one combinational read port.
// Assumes the read happens at most once per period, in the tick cycle; a write in
// that same cycle is seen only by later reads (old data is returned).
module pwm4_seq_table #(
    parameter int ADDR_W = 5,
    parameter int ENT_W  = 37,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ENT_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ENT_W-1:0]  rdata
);

    logic [ENT_W-1:0] mem [DEPTH];

    // Clear every entry on reset (all-zero is an invalid entry), else write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous read of the addressed entry.
    assign rdata = mem[raddr];

endmodule

// File: rtl/pwm4_seq_timer.sv
// Period timer: latches a validated entry on each tick, counts cycles and walks
// the four intervals. Assumes ticks arrive every PERIOD cycles; the count
// saturates at PERIOD-1 if a tick is late.
module pwm4_seq_timer
    import pwm4_seq_pkg::*;
#(
    parameter int PERIOD = 200,
    parameter int CNT_W  = 8,
    parameter int DLY_W  = 3,
    parameter int T3MAX  = 180,
    parameter int ENT_W  = 37
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               trip,
    input  logic [ENT_W-1:0]   ent_in,
    output logic               running,
    output seq_phase_e         phase,
    output logic [4*DLY_W-1:0] dly_cur,
    output logic               err
);

    logic [ENT_W-1:0] cur;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] n_t1, n_t2, n_t3, c_t1, c_t2, c_t3;
    logic             c_hp, ent_ok;

    assign n_t1 = ent_in[CNT_W-1:0];
    assign n_t2 = ent_in[2*CNT_W-1:CNT_W];
    assign n_t3 = ent_in[3*CNT_W-1:2*CNT_W];
    assign c_t1 = cur[CNT_W-1:0];
    assign c_t2 = cur[2*CNT_W-1:CNT_W];
    assign c_t3 = cur[3*CNT_W-1:2*CNT_W];
    assign c_hp = cur[ENT_W-1];

    // Ordering and cap check of the entry offered at the tick.
    assign ent_ok = (n_t1 < n_t2) && (n_t2 < n_t3) && (n_t3 <= CNT_W'(T3MAX));

    assign dly_cur = cur[ENT_W-2:3*CNT_W];

    // Latch entry on tick, count cycles and advance the interval at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur     <= '0;
            cnt     <= '0;
            phase   <= PH_A;
            running <= 1'b0;
            err     <= 1'b0;
        end else if (tick) begin
            cnt   <= '0;
            phase <= PH_A;
            err   <= !ent_ok;
            if (ent_ok) begin
                cur     <= ent_in;
                running <= 1'b1;
            end
        end else if (running) begin
            if (cnt != CNT_W'(PERIOD - 1)) cnt <= cnt + CNT_W'(1);
            unique case (phase)
                PH_A: if (cnt == c_t1) phase <= PH_B;
                PH_B: if (cnt == c_t2) phase <= PH_C;
                PH_C: if (cnt == c_t3 || (trip && !c_hp)) phase <= PH_D;
                PH_D: ;
            endcase
        end
    end

    // R7: the third interval never runs past the t3max cap.
    a_r7_t3_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (running && phase == PH_C) |-> (cnt <= CNT_W'(T3MAX)));

    // R4: without a tick, intervals only advance one step in order.
    a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && phase != $past(phase)) |-> (2'(phase) == 2'($past(phase)) + 2'd1));

    // R6: a comparator pulse before the t2 edge never ends the third interval.
    a_r6_early_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (running && phase == PH_B && trip && !tick) |=> (phase != PH_D));

    // R9: an invalid entry leaves the held entry untouched.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ent_ok) |=> (cur == $past(cur)));

endmodule

// File: rtl/pwm4_seq_deadtime.sv
// One half-bridge driver: when the wanted switch changes, both gates go off at
// once and the newcomer turns on after dly+1 cycles. Assumes dly is valid in
// the cycle the change is seen. While not armed both gates stay off.
module pwm4_seq_deadtime #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             sel,
    input  logic [DLY_W-1:0] dly,
    output logic             gate_lo,
    output logic             gate_hi
);

    logic             cur_sel;
    logic [DLY_W-1:0] dcnt;
    logic             en;

    // Track wanted switch, blank both gates and count the turn-on delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sel <= 1'b0;
            dcnt    <= '0;
            en      <= 1'b0;
        end else if (!arm) begin
            cur_sel <= sel;
            dcnt    <= '0;
            en      <= 1'b0;
        end else if (sel != cur_sel) begin
            cur_sel <= sel;
            dcnt    <= dly;
            en      <= 1'b0;
        end else if (dcnt != '0) begin
            dcnt <= dcnt - DLY_W'(1);
        end else begin
            en <= 1'b1;
        end
    end

    assign gate_lo = en && !cur_sel;
    assign gate_hi = en && cur_sel;

    // R10: the two switches of the pair are never on together.
    a_r10_pair_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_lo && gate_hi));

    // R5: a turn-off is never met by a partner turn-on in the same cycle.
    a_r5_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_lo) || $fell(gate_hi)) |-> !(gate_lo || gate_hi));

    // R1: an unarmed pair drives nothing.
    a_r1_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !(gate_lo || gate_hi));

endmodule

// File: rtl/pwm4_table_seq.sv
// Top: table lookup on each period tick, interval timer, and one dead-time
// driver per half-bridge (A: VT1/VT2, B: VT4/VT3). Assumes per_tick pulses
// every PERIOD clock cycles and table entries leave each interval longer than
// the delay that opens it.
module pwm4_table_seq
    import pwm4_seq_pkg::*;
#(
    parameter int PERIOD = 200,
    parameter int DLY_W  = 3,
    parameter int PW_W   = 3,
    parameter int VB_W   = 2,
    localparam int CNT_W  = $clog2(PERIOD),
    localparam int T3MAX  = PERIOD * 9 / 10,
    localparam int ADDR_W = PW_W + VB_W,
    localparam int ENT_W  = 1 + 4 * DLY_W + 3 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_tick,
    input  logic [PW_W-1:0]   pwr_cmd,
    input  logic [VB_W-1:0]   vbat_code,
    input  logic              cur_trip,
    input  logic              tab_we,
    input  logic [ADDR_W-1:0] tab_addr,
    input  logic [ENT_W-1:0]  tab_wdata,
    output logic [3:0]        gate,
    output logic              entry_err
);

    logic [ENT_W-1:0]   rd_ent;
    logic               run;
    seq_phase_e         phase;
    logic [4*DLY_W-1:0] dly_cur;
    logic [DLY_W-1:0]   d0, d1, d2, d3;
    logic               sel_v [2];
    logic [DLY_W-1:0]   dly_v [2];
    logic               lo_v  [2];
    logic               hi_v  [2];

    pwm4_seq_table #(.ADDR_W(ADDR_W), .ENT_W(ENT_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tab_we),
        .waddr (tab_addr),
        .wdata (tab_wdata),
        .raddr ({vbat_code, pwr_cmd}),
        .rdata (rd_ent)
    );

    pwm4_seq_timer #(
        .PERIOD (PERIOD), .CNT_W (CNT_W), .DLY_W (DLY_W),
        .T3MAX  (T3MAX),  .ENT_W (ENT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (per_tick),
        .trip    (cur_trip),
        .ent_in  (rd_ent),
        .running (run),
        .phase   (phase),
        .dly_cur (dly_cur),
        .err     (entry_err)
    );

    assign d0 = dly_cur[DLY_W-1:0];
    assign d1 = dly_cur[2*DLY_W-1:DLY_W];
    assign d2 = dly_cur[3*DLY_W-1:2*DLY_W];
    assign d3 = dly_cur[4*DLY_W-1:3*DLY_W];

    // Pair A wants VT2 in C/D (changes at start with d0, at edge 2 with d2);
    // pair B wants VT3 in B/C (changes at edge 1 with d1, at edge 3 with d3).
    always_comb begin
        sel_v[0] = (phase == PH_C) || (phase == PH_D);
        dly_v[0] = (phase == PH_A) ? d0 : d2;
        sel_v[1] = (phase == PH_B) || (phase == PH_C);
        dly_v[1] = (phase == PH_B) ? d1 : d3;
    end

    for (genvar p = 0; p < 2; p++) begin : g_pair
        pwm4_seq_deadtime #(.DLY_W(DLY_W)) u_dt (
            .clk     (clk),
            .rst_n   (rst_n),
            .arm     (run),
            .sel     (sel_v[p]),
            .dly     (dly_v[p]),
            .gate_lo (lo_v[p]),
            .gate_hi (hi_v[p])
        );
    end

    assign gate = {lo_v[1], hi_v[1], hi_v[0], lo_v[0]};

    // R1: nothing conducts before the first valid period has started.
    a_r1_gates_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (gate == 4'b0000));

endmodule

// File: tb/test_pwm4_table_seq.sv
module test_pwm4_table_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD = 200;
    localparam int T3MAX  = PERIOD * 9 / 10;
    localparam int EW     = 37;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        per_tick = 1'b0;
    logic [2:0]  pwr_cmd = '0;
    logic [1:0]  vbat_code = '0;
    logic        cur_trip = 1'b0;
    logic        tab_we = 1'b0;
    logic [4:0]  tab_addr = '0;
    logic [EW-1:0] tab_wdata = '0;
    logic [3:0]  gate;
    logic        entry_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [EW-1:0] exp_tab [32];
    logic [EW-1:0] held = '0;

    pwm4_table_seq i_pwm4_table_seq (
        .clk(clk), .rst_n(rst_n), .per_tick(per_tick), .pwr_cmd(pwr_cmd),
        .vbat_code(vbat_code), .cur_trip(cur_trip), .tab_we(tab_we),
        .tab_addr(tab_addr), .tab_wdata(tab_wdata), .gate(gate), .entry_err(entry_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [EW-1:0] pack(input bit hp, input int d0, input int d1,
        input int d2, input int d3, input int t1, input int t2, input int t3);
        return {hp, 3'(d3), 3'(d2), 3'(d1), 3'(d0), 8'(t3), 8'(t2), 8'(t1)};
    endfunction

    function automatic bit valid(input logic [EW-1:0] e);
        return (e[7:0] < e[15:8]) && (e[15:8] < e[23:16]) && (int'(e[23:16]) <= T3MAX);
    endfunction

    // Random valid entry: intervals at least 12 cycles, delays 0..7.
    function automatic logic [EW-1:0] mk(input bit hp);
        int t1 = 10 + int'($urandom % 30);
        int t2 = t1 + 12 + int'($urandom % 40);
        int t3 = hp ? T3MAX : t2 + 20 + int'($urandom % (T3MAX - t2 - 19));
        return pack(hp, $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8, t1, t2, t3);
    endfunction

    task automatic wr(input int a, input logic [EW-1:0] v);
        tab_we = 1'b1; tab_addr = 5'(a); tab_wdata = v;
        exp_tab[a] = v;
        @(negedge clk);
        tab_we = 1'b0;
    endtask

    // One period; entered and left at a negedge. c<0 means no comparator pulse.
    task automatic run_period(input int addr, input int c, input bit first,
        input bit wr_same, input logic [EW-1:0] wr_val, input int wr_mid, input string ctx);
        logic [EW-1:0] e;
        logic [3:0] prev, g;
        int fall[4], rise[4];
        int t1, t2, t3, d0, d1, d2, d3, te3;
        bit hp, v, excl_bad;
        per_tick = 1'b1;
        {vbat_code, pwr_cmd} = 5'(addr);
        cur_trip = 1'b0;
        if (wr_same) begin
            tab_we = 1'b1; tab_addr = 5'(addr); tab_wdata = wr_val;
        end
        v = valid(exp_tab[addr]);
        if (v) held = exp_tab[addr];
        if (wr_same) exp_tab[addr] = wr_val;
        e = held;
        t1 = e[7:0]; t2 = e[15:8]; t3 = e[23:16];
        d0 = e[26:24]; d1 = e[29:27]; d2 = e[32:30]; d3 = e[35:33]; hp = e[36];
        te3 = (!hp && c > t2 && c < t3) ? c : t3;
        @(negedge clk);
        per_tick = 1'b0; tab_we = 1'b0;
        chk(entry_err == !v, {ctx, " R9 entry_err"}, entry_err, !v);
        for (int i = 0; i < 4; i++) begin fall[i] = -1; rise[i] = -1; end
        excl_bad = 1'b0;
        prev = gate;
        for (int m = 1; m < PERIOD; m++) begin
            cur_trip = (c >= 0) && (m == c + 1);
            {vbat_code, pwr_cmd} = 5'($urandom);
            if (m == wr_mid) begin
                int wa = int'($urandom % 32);
                tab_we = 1'b1; tab_addr = 5'(wa); tab_wdata = mk(1'($urandom));
                exp_tab[wa] = tab_wdata;
            end else tab_we = 1'b0;
            @(negedge clk);
            g = gate;
            for (int i = 0; i < 4; i++) begin
                if (prev[i] && !g[i]) fall[i] = m;
                if (!prev[i] && g[i]) rise[i] = m;
            end
            if ((g[0] && g[1]) || (g[2] && g[3])) excl_bad = 1'b1;
            if (first && m == 1) chk(g == 4'b1001, {ctx, " R12 first turn-on"}, g, 4'b1001);
            if (m == t1 + 1) chk(g == 4'b1001, {ctx, " R3 interval A"}, g, 4'b1001);
            if (m == t2 + 1) chk(g == 4'b0101, {ctx, " R3 interval B"}, g, 4'b0101);
            if (m == te3 + 1) chk(g == 4'b0110, {ctx, " R3 interval C"}, g, 4'b0110);
            if (m == PERIOD - 1) chk(g == 4'b1010, {ctx, " R3 interval D"}, g, 4'b1010);
            prev = g;
        end
        cur_trip = 1'b0;
        chk(fall[3] == t1 + 2, {ctx, " R4 R2 VT4 off at edge 1"}, fall[3], t1 + 2);
        chk(rise[2] == t1 + 3 + d1, {ctx, " R5 VT3 on"}, rise[2], t1 + 3 + d1);
        chk(fall[0] == t2 + 2, {ctx, " R4 VT1 off at edge 2"}, fall[0], t2 + 2);
        chk(rise[1] == t2 + 3 + d2, {ctx, " R5 VT2 on"}, rise[1], t2 + 3 + d2);
        chk(fall[2] == te3 + 2, {ctx, hp ? " R8 edge 3" : (te3 != t3 ? " R6 edge 3" : " R7 edge 3")},
            fall[2], te3 + 2);
        chk(rise[3] == te3 + 3 + d3, {ctx, " R5 VT4 on"}, rise[3], te3 + 3 + d3);
        if (first) begin
            chk(rise[0] == 1, {ctx, " R12 VT1 on"}, rise[0], 1);
        end else begin
            chk(fall[1] == 1, {ctx, " R5 VT2 off at start"}, fall[1], 1);
            chk(rise[0] == 2 + d0, {ctx, " R5 VT1 on after d0"}, rise[0], 2 + d0);
        end
        chk(!excl_bad, {ctx, " R10 pair exclusion"}, excl_bad, 0);
    endtask

    function automatic int pick_c(input int a);
        int t2 = exp_tab[a][15:8];
        int t3 = exp_tab[a][23:16];
        int r = int'($urandom % 3);
        if (r == 0) return -1;
        if (r == 1) return int'($urandom % (t2 + 1));
        if (t3 - t2 > 13) return t2 + 12 + int'($urandom % (t3 - t2 - 12));
        return -1;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit r1_ok;
        void'($urandom(32'd7301));
        for (int i = 0; i < 32; i++) exp_tab[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        r1_ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (gate != 4'b0000 || entry_err) r1_ok = 1'b0;
        end
        chk(r1_ok, "R1 reset state", gate, 0);

        // R9: tick on an all-zero (invalid) entry before any valid one: stay idle.
        per_tick = 1'b1; {vbat_code, pwr_cmd} = 5'd0;
        @(negedge clk);
        per_tick = 1'b0;
        chk(entry_err == 1'b1, "R9 idle err", entry_err, 1);
        r1_ok = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (gate != 4'b0000) r1_ok = 1'b0;
        end
        chk(r1_ok, "R9 idle gates off", gate, 0);

        for (int a = 0; a < 32; a++) wr(a, mk(1'($urandom)));
        wr(5, pack(0, 3, 1, 4, 2, 20, 60, 150));
        run_period(5, -1, 1'b1, 1'b0, '0, -1, "first");

        for (int k = 0; k < 100; k++) begin
            int a = int'($urandom % 32);
            run_period(a, pick_c(a), 1'b0, 1'b0, '0,
                       ($urandom % 2) ? 20 + int'($urandom % 150) : -1, "random");
        end

        // R6 boundary: pulse at count t2 is ignored; pulses in the window move edge 3.
        wr(5, pack(0, 3, 1, 4, 2, 20, 60, 150));
        run_period(5, 60, 1'b0, 1'b0, '0, -1, "trip at t2");
        run_period(5, 80, 1'b0, 1'b0, '0, -1, "trip in window");
        run_period(5, 149, 1'b0, 1'b0, '0, -1, "trip before cap");
        run_period(5, 10, 1'b0, 1'b0, '0, -1, "trip early");
        // R8: high-power entry ignores the comparator.
        wr(6, pack(1, 7, 7, 7, 7, 30, 90, T3MAX));
        run_period(6, 100, 1'b0, 1'b0, '0, -1, "high mode");
        // R9: invalid entries reuse the held one.
        wr(7, pack(0, 1, 1, 1, 1, 50, 50, 120));
        run_period(7, -1, 1'b0, 1'b0, '0, -1, "bad order");
        wr(8, pack(0, 1, 1, 1, 1, 20, 60, T3MAX + 1));
        run_period(8, -1, 1'b0, 1'b0, '0, -1, "bad cap");
        // R11: write to the latched address on the tick cycle.
        run_period(5, -1, 1'b0, 1'b1, pack(0, 0, 5, 2, 6, 35, 100, 170), -1, "R11 same cycle");
        run_period(5, -1, 1'b0, 1'b0, '0, -1, "R11 next period");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule